// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight-bit status byte of a small accumulator-based processor. On each clock it takes the operation class of the instruction now in execute, the two ALU operands, the incoming carry and the current accumulator. From these it derives the new carry, half carry and signed overflow flags. The odd-parity bit is reloaded from the accumulator on every cycle.

Software reaches the byte in two ways. A whole-byte store writes every field except parity. A single-bit store writes one bit, chosen by its index. Two of the bits choose one of four eight-byte register windows, and the block outputs the base address of the window in use. When an arithmetic update and a software store land in the same cycle, the arithmetic flags win. The store still reaches the bits that the update does not touch.

Top module: `psw_unit`

## Requirements
- R1: After reset every bit of the status byte is 0 and the bank base output is 0.
- R2: Status byte layout: bit 7 carry, bit 6 half carry, bit 5 user flag A, bits 4:3 bank select (bit 4 high), bit 2 overflow, bit 1 user flag B, bit 0 parity. Operation codes: 0 none, 1 ADD, 2 ADDC, 3 SUBB, 4 MUL, 5 DIV, 6 other non-arithmetic.
- R3: Carry takes the carry out of bit 7 for ADD (carry-in ignored) and ADDC (carry-in added). For SUBB, which subtracts the second operand plus carry-in, carry takes the borrow.
- R4: Half carry is set on a carry out of bit 3 in ADD/ADDC, or a borrow into bit 3 in SUBB, and is cleared otherwise by these three operations.
- R5: For ADD, ADDC and SUBB, overflow is set exactly when the signed result changes sign wrongly (two's complement overflow).
- R6: MUL clears carry and half carry and sets overflow when the product is above 255. DIV clears carry and half carry and sets overflow when the divisor (second operand) is 0. In every other case both operations clear overflow.
- R7: Parity bit is 1 one cycle after the accumulator input holds an odd number of ones, 0 otherwise, and no software store changes it.
- R8: Bank base output equals the two bank-select bits times 8 (0x00, 0x08, 0x10, 0x18).
- R9: A byte store loads bits 7:1 from the write data on the next edge; data bit 0 is ignored.
- R10: A single-bit store writes data bit 0 into the bit named by the 3-bit index. Index 0 (parity) has no effect. A byte store takes precedence over a bit store.
- R11: If an arithmetic operation and a software store occur together, carry, half carry and overflow take the arithmetic result, while the other writable bits take the stored value.
- R12: Operation codes none and other leave carry, half carry and overflow unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Operation class code |
| opa_i | input | 8 | First ALU operand |
| opb_i | input | 8 | Second ALU operand (divisor for DIV) |
| cin_i | input | 1 | Carry/borrow in for ADDC and SUBB |
| acc_i | input | 8 | Current accumulator value |
| wr_byte_i | input | 1 | Whole-byte software store strobe |
| wr_bit_i | input | 1 | Single-bit software store strobe |
| wr_sel_i | input | 3 | Bit index for single-bit store |
| wr_data_i | input | 8 | Store data (bit 0 used for single-bit store) |
| status_o | output | 8 | Status byte |
| bank_base_o | output | 5 | Base address of the selected register window |
| cy_o | output | 1 | Carry flag |
| ac_o | output | 1 | Half carry flag |
| ov_o | output | 1 | Overflow flag |
| par_o | output | 1 | Parity flag |

## Verification
The arithmetic flag update and a software byte store can both target the register in one cycle. The bench provokes this by issuing an ADD together with a byte store whose data sets carry and overflow but clears half carry. The ADD gives the opposite values for those three bits. The result passes only if the three arithmetic bits show the ADD result and user flag A and the bank bits show the stored data.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 3'd0,
    OP_ADD   = 3'd1,
    OP_ADDC  = 3'd2,
    OP_SUBB  = 3'd3,
    OP_MUL   = 3'd4,
    OP_DIV   = 3'd5,
    OP_OTHER = 3'd6
  } alu_op_e;

  localparam int unsigned BIT_CY  = 7;
  localparam int unsigned BIT_AC  = 6;
  localparam int unsigned BIT_UFA = 5;
  localparam int unsigned BIT_BK1 = 4;
  localparam int unsigned BIT_BK0 = 3;
  localparam int unsigned BIT_OV  = 2;
  localparam int unsigned BIT_UFB = 1;
  localparam int unsigned BIT_PAR = 0;

  typedef struct packed {
    logic hit;
    logic cy;
    logic ac;
    logic ov;
  } flag_upd_t;
endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/psw_alu_flags.sv
module psw_alu_flags
  import psw_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   opa_i,
  input  logic [DW-1:0]   opb_i,
  input  logic            cin_i,
  output flag_upd_t       upd_o
);
  localparam int unsigned NW = DW / 2;

  logic [DW:0]     sum_w;
  logic [DW:0]     sub_w;
  logic [NW:0]     nib_sum;
  logic [NW:0]     nib_sub;
  logic [2*DW-1:0] prod_w;
  logic            cin_eff;

  always_comb begin
    cin_eff = (op_i == OP_ADD) ? 1'b0 : cin_i;
    sum_w   = {1'b0, opa_i} + {1'b0, opb_i} + {{DW{1'b0}}, cin_eff};
    sub_w   = {1'b0, opa_i} - {1'b0, opb_i} - {{DW{1'b0}}, cin_eff};
    nib_sum = {1'b0, opa_i[NW-1:0]} + {1'b0, opb_i[NW-1:0]} + {{NW{1'b0}}, cin_eff};
    nib_sub = {1'b0, opa_i[NW-1:0]} - {1'b0, opb_i[NW-1:0]} - {{NW{1'b0}}, cin_eff};
    prod_w  = opa_i * opb_i;
    upd_o   = '0;
    unique case (op_i)
      OP_ADD, OP_ADDC: begin
        upd_o.hit = 1'b1;
        upd_o.cy  = sum_w[DW];
        upd_o.ac  = nib_sum[NW];
        upd_o.ov  = (opa_i[DW-1] == opb_i[DW-1]) && (sum_w[DW-1] != opa_i[DW-1]);
      end
      OP_SUBB: begin
        upd_o.hit = 1'b1;
        upd_o.cy  = sub_w[DW];
        upd_o.ac  = nib_sub[NW];
        upd_o.ov  = (opa_i[DW-1] != opb_i[DW-1]) && (sub_w[DW-1] != opa_i[DW-1]);
      end
      OP_MUL: begin
        upd_o.hit = 1'b1;
        upd_o.ov  = |prod_w[2*DW-1:DW];
      end
      OP_DIV: begin
        upd_o.hit = 1'b1;
        upd_o.ov  = (opb_i == '0);
      end
      default: upd_o = '0;
    endcase
  end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned BANK_SZ = 8,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     op_i,
  input  logic [DW-1:0]  opa_i,
  input  logic [DW-1:0]  opb_i,
  input  logic           cin_i,
  input  logic [DW-1:0]  acc_i,
  input  logic           wr_byte_i,
  input  logic           wr_bit_i,
  input  logic [2:0]     wr_sel_i,
  input  logic [7:0]     wr_data_i,
  output logic [7:0]     status_o,
  output logic [ADDR_W-1:0] bank_base_o,
  output logic           cy_o,
  output logic           ac_o,
  output logic           ov_o,
  output logic           par_o
);
  localparam int unsigned BANK_SH = $clog2(BANK_SZ);

  logic      rst_sync_n;
  flag_upd_t upd;
  logic [7:1] flags_q, flags_d;
  logic       flags_en;
  logic       par_q, par_d;

  psw_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  psw_alu_flags #(.DW(DW)) u_flags (
    .op_i (op_i),
    .opa_i(opa_i),
    .opb_i(opb_i),
    .cin_i(cin_i),
    .upd_o(upd)
  );

  // next state: software store first, arithmetic flags override it
  always_comb begin
    flags_d = flags_q;
    if (wr_byte_i) begin
      flags_d = wr_data_i[7:1];
    end else if (wr_bit_i && (wr_sel_i != 3'd0)) begin
      flags_d[wr_sel_i] = wr_data_i[0];
    end
    if (upd.hit) begin
      flags_d[BIT_CY] = upd.cy;
      flags_d[BIT_AC] = upd.ac;
      flags_d[BIT_OV] = upd.ov;
    end
    flags_en = upd.hit | wr_byte_i | wr_bit_i;
    par_d    = ^acc_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flags_q <= '0;
      par_q   <= 1'b0;
    end else begin
      if (flags_en) flags_q <= flags_d;
      par_q <= par_d;
    end
  end

  assign status_o    = {flags_q, par_q};
  assign bank_base_o = ADDR_W'({flags_q[BIT_BK1], flags_q[BIT_BK0]}) << BANK_SH;
  assign cy_o        = flags_q[BIT_CY];
  assign ac_o        = flags_q[BIT_AC];
  assign ov_o        = flags_q[BIT_OV];
  assign par_o       = par_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((op_i == OP_NONE || op_i == OP_OTHER) && !wr_byte_i && !wr_bit_i)
      |=> $stable(status_o[7:1])) else $error("idle hold"); // R12
  AST_MULDIV_CLR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == OP_MUL || op_i == OP_DIV) |=> (!cy_o && !ac_o)) else $error("muldiv clear"); // R6
  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == OP_DIV && opb_i == '0) |=> ov_o) else $error("div zero"); // R6
  AST_PARITY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> (par_o == ^$past(acc_i))) else $error("parity"); // R7
  AST_STORE_KEEPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i inside {OP_ADD, OP_ADDC, OP_SUBB} && wr_byte_i)
      |=> (status_o[BIT_UFA] == $past(wr_data_i[BIT_UFA]))) else $error("store"); // R11
  AST_BANK_ALIGN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ($past(wr_byte_i) -> bank_base_o[BANK_SH-1:0] == '0)) else $error("bank"); // R8
endmodule

// File: tb/tb_psw_unit.sv
module tb_psw_unit;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] opa_i = '0, opb_i = '0, acc_i = '0, wr_data_i = '0;
  logic       cin_i = 1'b0, wr_byte_i = 1'b0, wr_bit_i = 1'b0;
  logic [2:0] wr_sel_i = '0;
  logic [7:0] status_o;
  logic [4:0] bank_base_o;
  logic       cy_o, ac_o, ov_o, par_o;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  psw_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    op_i = 3'd0; wr_byte_i = 0; wr_bit_i = 0; cin_i = 0; acc_i = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic arith(logic [2:0] op, logic [7:0] a, logic [7:0] b, logic c);
    op_i = op; opa_i = a; opb_i = b; cin_i = c; acc_i = 0;
    step();
  endtask

  task automatic bytewr(logic [7:0] d);
    wr_byte_i = 1; wr_data_i = d; step();
  endtask

  task automatic bitwr(logic [2:0] s, logic v);
    wr_bit_i = 1; wr_sel_i = s; wr_data_i = {7'd0, v}; step();
  endtask

  task automatic t_reset();
    check("R1 status", status_o, 8'h00);
    check("R1 bank", {3'd0, bank_base_o}, 8'h00);
  endtask

  task automatic t_add();
    arith(3'd1, 8'h80, 8'h80, 0); check("R3 R5 add 80+80", status_o, 8'h84);
    check("R2 cy pin", {7'd0, cy_o}, 8'h01);
    arith(3'd1, 8'h0F, 8'h01, 0); check("R4 add half carry", status_o, 8'h40);
    check("R2 ac pin", {7'd0, ac_o}, 8'h01);
    arith(3'd1, 8'h7F, 8'h01, 0); check("R5 add overflow", status_o, 8'h44);
    arith(3'd1, 8'hFF, 8'h00, 1); check("R3 add ignores cin", status_o, 8'h00);
    arith(3'd2, 8'hFF, 8'h00, 1); check("R3 addc uses cin", status_o, 8'hC0);
  endtask

  task automatic t_subb();
    arith(3'd3, 8'h00, 8'h01, 0); check("R3 subb borrow", status_o, 8'hC0);
    arith(3'd3, 8'h80, 8'h01, 0); check("R5 subb overflow", status_o, 8'h44);
    check("R2 ov pin", {7'd0, ov_o}, 8'h01);
    arith(3'd3, 8'h10, 8'h0F, 1); check("R4 subb half borrow", status_o, 8'h40);
  endtask

  task automatic t_muldiv();
    arith(3'd1, 8'h80, 8'h80, 0);
    arith(3'd4, 8'h0F, 8'h11, 0); check("R6 mul 255", status_o, 8'h00);
    arith(3'd4, 8'h10, 8'h10, 0); check("R6 mul 256", status_o, 8'h04);
    arith(3'd5, 8'h05, 8'h00, 0); check("R6 div zero", status_o, 8'h04);
    arith(3'd5, 8'h05, 8'h01, 0); check("R6 div ok", status_o, 8'h00);
  endtask

  task automatic t_parity();
    acc_i = 8'h07; @(negedge clk);
    check("R7 odd", {7'd0, par_o}, 8'h01);
    acc_i = 8'h03; @(negedge clk);
    check("R7 even", status_o, 8'h00);
    acc_i = 8'h01; wr_byte_i = 1; wr_data_i = 8'h00; @(negedge clk);
    check("R7 store ignored", status_o, 8'h01);
    idle(); @(negedge clk);
  endtask

  task automatic t_writes();
    bytewr(8'hFF); check("R9 byte store", status_o, 8'hFE);
    bytewr(8'h08); check("R8 bank 1", {3'd0, bank_base_o}, 8'h08);
    bitwr(3'd4, 1); bitwr(3'd3, 1); check("R8 bank 3", {3'd0, bank_base_o}, 8'h18);
    bitwr(3'd0, 1); check("R10 index 0 ignored", status_o, 8'h18);
    bitwr(3'd1, 1); check("R10 bit 1", status_o, 8'h1A);
    wr_bit_i = 1; wr_sel_i = 3'd5; wr_byte_i = 1; wr_data_i = 8'h00; step();
    check("R10 byte over bit", status_o, 8'h00);
  endtask

  task automatic t_collide();
    op_i = 3'd1; opa_i = 8'h0F; opb_i = 8'h01; wr_byte_i = 1; wr_data_i = 8'hA5;
    step(); check("R11 flags win", status_o, 8'h60);
  endtask

  task automatic t_hold();
    op_i = 3'd6; opa_i = 8'hFF; opb_i = 8'hFF; step(); step();
    check("R12 other op hold", status_o, 8'h60);
    op_i = 3'd0; opa_i = 8'h80; opb_i = 8'h80; step();
    check("R12 none hold", status_o, 8'h60);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_add();
    t_subb();
    t_muldiv();
    t_parity();
    t_writes();
    t_collide();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule